// File: doc/BRIEF.md
# Wired-OR Bus Master Controller

This block is the master side of a shared on-chip bus. On that bus the outputs of all masters are ORed together. User logic gives it a one-cycle start together with a direction, a start address, a word count and write data. The controller then requests the bus from the central arbiter and waits for grant. It asserts select and moves one word per select phase until the count is used up or the bus ends the sequence early.

Every bus output is forced to zero whenever the controller is not driving a transfer, so it can sit on the OR array beside other masters with no extra gating. For a multi-word sequence the controller holds bus lock from the grant onward and releases it on the acknowledge of the next-to-last word. When a slave asks for a retry, the controller re-arbitrates for the same word, up to a set number of attempts. It reports the end of each sequence with a one-cycle done pulse and a two-bit status. Each acknowledged word gives a one-cycle word pulse; on reads that pulse comes with the captured data.

Top module: `wob_master`

## Requirements
- R1: While idle, req_o, sel_o, lock_o, rnw_o, abus_o and dbus_o are all zero. Whenever sel_o is low, abus_o, dbus_o and rnw_o are zero. During select, rnw_o is 1 for a read, and dbus_o carries wdata_i for a write and zero for a read.
- R2: One cycle after an accepted start, req_o is high, and it stays high in every cycle until gnt_i is sampled high.
- R3: In the cycle after gnt_i is sampled with req_o high, sel_o is high and req_o is low.
- R4: In the cycle after a select cycle that has xack_i, errack_i, tmo_i or retry_i high, sel_o is low.
- R5: When count is above 1, lock_o rises together with sel_o after grant. It stays high through the one-cycle gap between words and goes low in the cycle after the acknowledge of the next-to-last word. lock_o is never high for a one-word sequence.
- R6: The first select presents addr_i on abus_o. Each acknowledged word adds 4 to the address of the next word. A count of 0 runs as one word. After an accepted acknowledge, sel_o is low for one cycle and then high again without a new request.
- R7: For a read, rdbus_i sampled in a select cycle with xack_i high appears on rdata_o in the next cycle, together with a one-cycle word_ack_o. Writes also pulse word_ack_o and leave rdata_o unchanged.
- R8: On retry_i, sel_o and lock_o drop and req_o rises in the next cycle. After the next grant the same address is presented again. Once a single word has been retried RETRY_MAX times, the next retry ends the sequence with status 3.
- R9: errack_i or tmo_i during select ends the sequence in the next cycle with done_o high, lock_o low, busy_o low and status 1 or 2. Priority is error, then timeout, then retry, then acknowledge. A lower-priority response in the same cycle has no effect, so no word_ack_o is given.
- R10: After the acknowledge of the last word, done_o is high for exactly one cycle with status_o = 0 (0 ok, 1 error, 2 timeout, 3 retry exhausted). status_o holds its value until the next done.
- R11: busy_o is high from the cycle after an accepted start until done. A start while busy is ignored: it changes neither the address in use nor the state after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sequence (accepted only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Start byte address |
| wdata_i | input | DW | Write data for the current word |
| count_i | input | CNT_W | Word count (0 runs as 1) |
| busy_o | output | 1 | Sequence in progress |
| word_ack_o | output | 1 | One word completed |
| rdata_o | output | DW | Last read word |
| done_o | output | 1 | Sequence finished pulse |
| status_o | output | 2 | Completion code |
| gnt_i | input | 1 | Arbiter grant |
| xack_i | input | 1 | Transfer acknowledge |
| errack_i | input | 1 | Error acknowledge |
| tmo_i | input | 1 | Bus timeout |
| retry_i | input | 1 | Slave retry |
| rdbus_i | input | DW | Read data from the OR bus |
| req_o | output | 1 | Bus request |
| sel_o | output | 1 | Select |
| lock_o | output | 1 | Bus lock |
| rnw_o | output | 1 | Read strobe, 1 = read |
| abus_o | output | AW | Address to the OR bus |
| dbus_o | output | DW | Write data to the OR bus |

## Verification
Several slave responses can fall in the same select cycle. The case that matters most is an error acknowledge that arrives with the transfer acknowledge of the final word. The bench raises both in one cycle during a read. It then expects status 1, no word pulse and rdata_o unchanged, which shows that the error won and the acknowledge was dropped. A second overlap, a start that arrives while a sequence waits for grant, is judged by the address put on the bus and by busy_o staying low after done.

// File: rtl/wob_pkg.sv
package wob_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_SEL, ST_GAP} st_e;
  typedef enum logic [1:0] {STS_OK = 2'd0, STS_ERR = 2'd1, STS_TMO = 2'd2, STS_RTY = 2'd3} sts_e;
  typedef enum logic [2:0] {RSP_NONE, RSP_ACK, RSP_RTY, RSP_TMO, RSP_ERR} rsp_e;

  // error > timeout > retry > acknowledge
  function automatic rsp_e rsp_decode(input logic err, input logic tmo,
                                      input logic rty, input logic ack);
    if (err)      return RSP_ERR;
    else if (tmo) return RSP_TMO;
    else if (rty) return RSP_RTY;
    else if (ack) return RSP_ACK;
    else          return RSP_NONE;
  endfunction
endpackage

// File: rtl/wob_addr.sv
module wob_addr #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          incr_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o
);
  localparam int STEP = DW / 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      wr_o   <= 1'b0;
    end else if (load_i) begin
      addr_o <= addr_i;
      wr_o   <= wr_i;
    end else if (incr_i) begin
      addr_o <= addr_o + AW'(STEP);
    end
  end

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incr_i && !load_i |=> addr_o == $past(addr_o) + AW'(STEP));
endmodule

// File: rtl/wob_fsm.sv
module wob_fsm import wob_pkg::*; #(
  parameter int CNT_W   = 8,
  parameter int RTY_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             gnt_i,
  input  rsp_e             rsp_i,
  output st_e              st_o,
  output logic             lock_o,
  output logic             done_o,
  output sts_e             status_o,
  output logic             word_ack_o,
  output logic             load_o,
  output logic             incr_o
);
  localparam int RC_W = (RTY_MAX < 1) ? 1 : $clog2(RTY_MAX + 1);

  st_e              st_q;
  logic [CNT_W-1:0] rem_q;
  logic [RC_W-1:0]  rty_q;
  rsp_e             rsp;

  assign rsp    = (st_q == ST_SEL) ? rsp_i : RSP_NONE;
  assign load_o = (st_q == ST_IDLE) && start_i;
  assign incr_o = (rsp == RSP_ACK);
  assign st_o   = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      rty_q      <= '0;
      lock_o     <= 1'b0;
      done_o     <= 1'b0;
      word_ack_o <= 1'b0;
      status_o   <= STS_OK;
    end else begin
      done_o     <= 1'b0;
      word_ack_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_REQ;
          rem_q <= (count_i == '0) ? CNT_W'(1) : count_i;
          rty_q <= '0;
        end
        ST_REQ: if (gnt_i) begin
          st_q   <= ST_SEL;
          lock_o <= (rem_q > CNT_W'(1));
        end
        ST_SEL: begin
          unique case (rsp)
            RSP_ACK: begin
              word_ack_o <= 1'b1;
              rty_q      <= '0;
              if (rem_q == CNT_W'(1)) begin
                st_q     <= ST_IDLE;
                lock_o   <= 1'b0;
                done_o   <= 1'b1;
                status_o <= STS_OK;
              end else begin
                st_q  <= ST_GAP;
                rem_q <= rem_q - CNT_W'(1);
                if (rem_q == CNT_W'(2)) lock_o <= 1'b0;
              end
            end
            RSP_RTY: begin
              lock_o <= 1'b0;
              if (rty_q == RC_W'(RTY_MAX)) begin
                st_q     <= ST_IDLE;
                done_o   <= 1'b1;
                status_o <= STS_RTY;
              end else begin
                rty_q <= rty_q + RC_W'(1);
                st_q  <= ST_REQ;
              end
            end
            RSP_TMO, RSP_ERR: begin
              st_q     <= ST_IDLE;
              lock_o   <= 1'b0;
              done_o   <= 1'b1;
              status_o <= (rsp == RSP_ERR) ? STS_ERR : STS_TMO;
            end
            default: ;
          endcase
        end
        ST_GAP: st_q <= ST_SEL;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r8_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rty_q <= RC_W'(RTY_MAX));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/wob_gate.sv
module wob_gate import wob_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  st_e           st_i,
  input  logic          wr_i,
  input  logic          lock_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o,
  output logic          sel_o,
  output logic          lock_o,
  output logic          rnw_o,
  output logic [AW-1:0] abus_o,
  output logic [DW-1:0] dbus_o
);
  // zero when not driving: the bus is the OR of all masters
  always_comb begin
    req_o  = (st_i == ST_REQ);
    sel_o  = (st_i == ST_SEL);
    lock_o = lock_i && (st_i != ST_IDLE);
    rnw_o  = sel_o && !wr_i;
    abus_o = sel_o ? addr_i : '0;
    dbus_o = (sel_o && wr_i) ? wdata_i : '0;
  end
endmodule

// File: rtl/wob_master.sv
module wob_master import wob_pkg::*; #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CNT_W   = 8,
  parameter int RTY_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             word_ack_o,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  input  logic             gnt_i,
  input  logic             xack_i,
  input  logic             errack_i,
  input  logic             tmo_i,
  input  logic             retry_i,
  input  logic [DW-1:0]    rdbus_i,
  output logic             req_o,
  output logic             sel_o,
  output logic             lock_o,
  output logic             rnw_o,
  output logic [AW-1:0]    abus_o,
  output logic [DW-1:0]    dbus_o
);
  st_e           st;
  sts_e          sts;
  rsp_e          rsp;
  logic          lock_q, load, incr, wr_q;
  logic [AW-1:0] addr_q;

  assign rsp      = rsp_decode(errack_i, tmo_i, retry_i, xack_i);
  assign busy_o   = (st != ST_IDLE);
  assign status_o = sts;

  wob_fsm #(.CNT_W(CNT_W), .RTY_MAX(RTY_MAX)) u_fsm (
    .clk_i, .rst_ni, .start_i, .count_i, .gnt_i,
    .rsp_i(rsp), .st_o(st), .lock_o(lock_q), .done_o, .status_o(sts),
    .word_ack_o, .load_o(load), .incr_o(incr)
  );

  wob_addr #(.AW(AW), .DW(DW)) u_addr (
    .clk_i, .rst_ni, .load_i(load), .incr_i(incr), .wr_i, .addr_i,
    .wr_o(wr_q), .addr_o(addr_q)
  );

  wob_gate #(.AW(AW), .DW(DW)) u_gate (
    .st_i(st), .wr_i(wr_q), .lock_i(lock_q), .addr_i(addr_q), .wdata_i,
    .req_o, .sel_o, .lock_o, .rnw_o, .abus_o, .dbus_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (incr && !wr_q) rdata_o <= rdbus_i;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o && !sel_o && !lock_o && !rnw_o && abus_o == '0 && dbus_o == '0);
  a_r1_nosel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> abus_o == '0 && dbus_o == '0 && !rnw_o);
  a_r2_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> req_o);
  a_r3_sel_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i |=> sel_o && !req_o);
  a_r4_sel_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o && (xack_i || errack_i || tmo_i || retry_i) |=> !sel_o);
  a_r9_err_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o && errack_i |=> done_o && status_o == 2'd1 && !lock_o && !busy_o && !word_ack_o);
  a_r5_lock_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> busy_o && !req_o);
endmodule

// File: tb/sim_wob_master.sv
module sim_wob_master;
  localparam int AW = 32, DW = 32, CNT_W = 8, RTY_MAX = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wr = 0, gnt = 0, xack = 0, errack = 0, tmo = 0, retry = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdbus = '0;
  logic [CNT_W-1:0] count = '0;
  logic busy, word_ack, done, req, sel, lock, rnw;
  logic [DW-1:0] rdata, dbus;
  logic [AW-1:0] abus;
  logic [1:0] status;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wob_master #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .RTY_MAX(RTY_MAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .count_i(count), .busy_o(busy), .word_ack_o(word_ack),
    .rdata_o(rdata), .done_o(done), .status_o(status), .gnt_i(gnt),
    .xack_i(xack), .errack_i(errack), .tmo_i(tmo), .retry_i(retry),
    .rdbus_i(rdbus), .req_o(req), .sel_o(sel), .lock_o(lock), .rnw_o(rnw),
    .abus_o(abus), .dbus_o(dbus)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic launch(input logic w, input logic [AW-1:0] a, input logic [CNT_W-1:0] n);
    start = 1; wr = w; addr = a; count = n;
    step();
    start = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset req/sel/lock", {req, sel, lock, rnw}, 0);
    chk("R1 reset abus", abus, 0);
    chk("R1 reset dbus", dbus, 0);
    chk("R10 reset done/status", {done, status}, 0);
  endtask

  task automatic t_single_read();
    launch(0, 32'h1000, 1);
    chk("R2 req after start", {req, sel, busy}, 3'b101);
    step();
    chk("R2 req held", req, 1);
    start = 1; addr = 32'h2000; // R11: ignored while busy
    step();
    start = 0;
    chk("R2 req held 2", req, 1);
    gnt = 1;
    step();
    gnt = 0;
    chk("R3 sel after gnt", {sel, req}, 2'b10);
    chk("R5 no lock single", lock, 0);
    chk("R11 addr unchanged", abus, 32'h1000);
    chk("R1 read rnw/dbus", {31'h0, rnw} | dbus, 1);
    xack = 1; rdbus = 32'hCAFE0001;
    step();
    xack = 0; rdbus = '0;
    chk("R4 sel drop", sel, 0);
    chk("R10 done ok", {done, status}, 3'b100);
    chk("R7 word_ack", word_ack, 1);
    chk("R7 rdata", rdata, 32'hCAFE0001);
    chk("R1 idle abus", abus, 0);
    step();
    chk("R10 done one cycle", done, 0);
    chk("R11 busy stays low", busy, 0);
  endtask

  task automatic t_burst_write();
    launch(1, 32'h40, 3);
    gnt = 1; wdata = 32'hA0;
    step();
    gnt = 0;
    chk("R5 lock with sel", {sel, lock}, 2'b11);
    chk("R6 addr word0", abus, 32'h40);
    chk("R1 write dbus", dbus, 32'hA0);
    chk("R1 write rnw", rnw, 0);
    xack = 1;
    step();
    xack = 0; wdata = 32'hA1;
    chk("R6 gap", {sel, req, lock}, 3'b001);
    chk("R7 write word_ack", word_ack, 1);
    chk("R7 rdata kept on write", rdata, 32'hCAFE0001);
    step();
    chk("R6 addr word1", abus, 32'h44);
    chk("R1 dbus word1", dbus, 32'hA1);
    chk("R5 lock word1", lock, 1);
    xack = 1;
    step();
    xack = 0; wdata = 32'hA2;
    chk("R5 lock released after next-to-last", lock, 0);
    step();
    chk("R6 addr word2", abus, 32'h48);
    chk("R5 lock last word", {sel, lock}, 2'b10);
    xack = 1;
    step();
    xack = 0;
    chk("R10 burst done", {done, status, busy}, 4'b1000);
  endtask

  task automatic t_retry();
    launch(0, 32'h80, 2);
    gnt = 1;
    step();
    gnt = 0;
    chk("R5 lock burst read", lock, 1);
    retry = 1;
    step();
    retry = 0;
    chk("R8 rerequest", {req, sel, lock}, 3'b100);
    gnt = 1;
    step();
    gnt = 0;
    chk("R8 same addr", abus, 32'h80);
    xack = 1; rdbus = 32'h11;
    step();
    xack = 0;
    step();
    chk("R6 addr after retry ack", abus, 32'h84);
    for (int i = 0; i < RTY_MAX; i++) begin
      retry = 1;
      step();
      retry = 0;
      chk("R8 retry within limit", {req, done}, 2'b10);
      gnt = 1;
      step();
      gnt = 0;
      chk("R8 reselect same addr", abus, 32'h84);
    end
    retry = 1;
    step();
    retry = 0;
    chk("R8 retry exhausted", {done, status, busy}, 4'b1110);
    chk("R8 no lock at end", lock, 0);
  endtask

  task automatic t_err_with_ack();
    launch(0, 32'h200, 1);
    gnt = 1;
    step();
    gnt = 0;
    errack = 1; xack = 1; rdbus = 32'hDEAD;
    step();
    errack = 0; xack = 0;
    chk("R9 error wins", {done, status, busy}, 4'b1010);
    chk("R9 no word_ack", word_ack, 0);
    chk("R9 rdata unchanged", rdata, 32'h11);
  endtask

  task automatic t_timeout_burst();
    launch(1, 32'h300, 4);
    gnt = 1;
    step();
    gnt = 0;
    xack = 1;
    step();
    xack = 0;
    step();
    chk("R5 lock mid burst", lock, 1);
    tmo = 1; retry = 1;
    step();
    tmo = 0; retry = 0;
    chk("R9 timeout status", {done, status}, 3'b110);
    chk("R9 lock/busy released", {lock, busy, req}, 0);
  endtask

  task automatic t_zero_count();
    launch(0, 32'h500, 0);
    gnt = 1;
    step();
    gnt = 0;
    chk("R6 count0 lock", {sel, lock}, 2'b10);
    xack = 1; rdbus = 32'h77;
    step();
    xack = 0;
    chk("R6 count0 one word", {done, status, busy}, 4'b1000);
    chk("R7 count0 rdata", rdata, 32'h77);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_single_read();
    t_burst_write();
    t_retry();
    t_err_with_ack();
    t_timeout_burst();
    t_zero_count();
    step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule